// File: doc/BRIEF.md
# Interrupt Cause Collector with Polarity-Selectable Request Pin

This block gathers single-cycle event pulses from a USB device core (endpoint packet events, the setup-stage event, frame-start, bus reset, suspend and similar) into sticky status bits. A local microcontroller sees these bits through a byte-wide register bus that has an address, a read strobe, a write strobe and write/read data. Each status byte has a matching enable byte. One request pin is driven whenever an enabled status bit is set. Firmware picks whether that pin is active high or active low.

Firmware clears a status bit by writing a 1 to its position. The setup-stage event is held in one flop. That flop appears in two places: bit 2 of the endpoint-0 status byte, and bit 0 of the first status byte. Clearing the bit through either address clears both views. Reads have no side effects. Unmapped addresses read as zero and ignore writes.

Top module: `irq_aggregator`

## Requirements
- R1: After reset every status, enable and polarity bit is 0. Every mapped address reads 00h, and `irq_o` is 1, which is the inactive level for active-low.
- R2: A one-cycle pulse on `ep_evt_i[i]` sets bit i+1 of the status byte at 21h. A pulse on `bus_evt_i[i]` sets bit i of the status byte at 22h (bit 0 frame start, bit 1 bus reset, bit 3 suspend). A set bit stays set after the pulse ends.
- R3: A write of data D to 21h or 22h clears exactly the status bits where D has a 1. Bits where D has a 0 are left unchanged.
- R4: If an event and a clear of the same bit fall in the same cycle, the bit is 1 afterwards.
- R5: A `setup_evt_i` pulse sets bit 2 of the byte at 60h and bit 0 of the byte at 21h. Writing 1 to either of those positions clears both. The other bits of 60h read 0.
- R6: The enable bytes at 24h (for status 21h) and 25h (for status 22h) are read/write and gate their status byte bit for bit.
- R7: The request is pending exactly when some status bit is 1 and its enable bit is 1. `irq_o` reflects a register change from the clock edge that makes it.
- R8: Bit 0 of the byte at 30h selects the pin polarity: 0 means active low, 1 means active high. The other bits read 0.
- R9: A read of any unmapped address returns 00h. A write to an unmapped address changes no register.
- R10: Reading a status byte does not clear it.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| addr_i | input | 8 | Register address |
| rd_i | input | 1 | Read strobe; `rdata_o` is valid while it is high |
| wr_i | input | 1 | Write strobe; the write takes effect at the clock edge |
| wdata_i | input | 8 | Write data |
| rdata_o | output | 8 | Read data, 00h when `rd_i` is low |
| ep_evt_i | input | 7 | Endpoint cause pulses, mapped to status 21h bits 7..1 |
| setup_evt_i | input | 1 | Setup-stage-stored pulse |
| bus_evt_i | input | 8 | Bus cause pulses, mapped to status 22h bits 7..0 |
| irq_o | output | 1 | Interrupt request pin |

## Verification
Event patterns are tried on both status bytes. Mixed multi-bit pulses show whether the bit mapping and the stickiness are correct. Partial write-1 masks show whether clearing is selective or wipes the whole byte. A colliding event-and-clear cycle shows whether set beats clear. The setup event is cleared through each of its two addresses, which shows that the two views share one flop. The request pin is checked under both polarities and with enables that match or miss the pending bits. This separates the gating from the polarity inversion. Unmapped reads and writes are followed by read-back of every mapped register.

// File: rtl/irq_agg_pkg.sv
package irq_agg_pkg;
  localparam int ADDR_W = 8;
  localparam int DATA_W = 8;
  localparam int EP_W   = DATA_W - 1;

  localparam logic [ADDR_W-1:0] A_STAT1 = 8'h21;
  localparam logic [ADDR_W-1:0] A_STAT2 = 8'h22;
  localparam logic [ADDR_W-1:0] A_EN1   = 8'h24;
  localparam logic [ADDR_W-1:0] A_EN2   = 8'h25;
  localparam logic [ADDR_W-1:0] A_POL   = 8'h30;
  localparam logic [ADDR_W-1:0] A_EP0   = 8'h60;
  localparam int EP0_SETUP_BIT = 2;

  // Sticky next state: a set overrides a clear of the same bit.
  function automatic logic sticky_next(input logic q, input logic set, input logic clr);
    return set | (q & ~clr);
  endfunction

  // Request pending when any status bit meets its enable.
  function automatic logic pending_of(input logic [DATA_W-1:0] s1, input logic [DATA_W-1:0] e1,
                                      input logic [DATA_W-1:0] s2, input logic [DATA_W-1:0] e2);
    return (|(s1 & e1)) | (|(s2 & e2));
  endfunction
endpackage

// File: rtl/irq_sticky_bank.sv
module irq_sticky_bank #(
  parameter int W = 8
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] set_i,
  input  logic [W-1:0] clr_i,
  output logic [W-1:0] q_o
);
  import irq_agg_pkg::*;

  for (genvar i = 0; i < W; i++) begin : g_bit
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) q_o[i] <= 1'b0;
      else        q_o[i] <= sticky_next(q_o[i], set_i[i], clr_i[i]);
    end
  end

  // R2 R4
  set_sticks_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (|set_i) |=> ((q_o & $past(set_i)) == $past(set_i)));

  // R3
  clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (|(clr_i & ~set_i)) |=> ((q_o & $past(clr_i & ~set_i)) == '0));

  // R10
  hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (set_i == '0 && clr_i == '0) |=> $stable(q_o));
endmodule

// File: rtl/irq_regfile.sv
module irq_regfile
  import irq_agg_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic [ADDR_W-1:0] addr_i,
  input  logic              rd_i,
  input  logic              wr_i,
  input  logic [DATA_W-1:0] wdata_i,
  input  logic [DATA_W-1:0] stat1_i,
  input  logic [DATA_W-1:0] stat2_i,
  input  logic [DATA_W-1:0] ep0_i,
  output logic [DATA_W-1:0] clr1_o,
  output logic [DATA_W-1:0] clr2_o,
  output logic              clr_setup_ep0_o,
  output logic [DATA_W-1:0] en1_o,
  output logic [DATA_W-1:0] en2_o,
  output logic              pol_o,
  output logic [DATA_W-1:0] rdata_o
);
  logic hit;
  assign hit = (addr_i == A_STAT1) || (addr_i == A_STAT2) || (addr_i == A_EN1) ||
               (addr_i == A_EN2)   || (addr_i == A_POL)   || (addr_i == A_EP0);

  assign clr1_o          = (wr_i && addr_i == A_STAT1) ? wdata_i : '0;
  assign clr2_o          = (wr_i && addr_i == A_STAT2) ? wdata_i : '0;
  assign clr_setup_ep0_o = wr_i && (addr_i == A_EP0) && wdata_i[EP0_SETUP_BIT];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      en1_o <= '0;
      en2_o <= '0;
      pol_o <= 1'b0;
    end else if (wr_i) begin
      if (addr_i == A_EN1) en1_o <= wdata_i;
      if (addr_i == A_EN2) en2_o <= wdata_i;
      if (addr_i == A_POL) pol_o <= wdata_i[0];
    end
  end

  always_comb begin
    rdata_o = '0;
    if (rd_i) begin
      case (addr_i)
        A_STAT1: rdata_o = stat1_i;
        A_STAT2: rdata_o = stat2_i;
        A_EN1:   rdata_o = en1_o;
        A_EN2:   rdata_o = en2_o;
        A_POL:   rdata_o = {{(DATA_W-1){1'b0}}, pol_o};
        A_EP0:   rdata_o = ep0_i;
        default: rdata_o = '0;
      endcase
    end
  end

  // R9
  unmapped_rd_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_i && !hit) |-> (rdata_o == '0));

  // R9
  unmapped_wr_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_i && !hit) |=> ($stable(en1_o) && $stable(en2_o) && $stable(pol_o)));
endmodule

// File: rtl/irq_aggregator.sv
module irq_aggregator
  import irq_agg_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic [ADDR_W-1:0] addr_i,
  input  logic              rd_i,
  input  logic              wr_i,
  input  logic [DATA_W-1:0] wdata_i,
  output logic [DATA_W-1:0] rdata_o,
  input  logic [EP_W-1:0]   ep_evt_i,
  input  logic              setup_evt_i,
  input  logic [DATA_W-1:0] bus_evt_i,
  output logic              irq_o
);
  logic [DATA_W-1:0] clr1, clr2, en1, en2, stat1, stat2, ep0_view;
  logic [EP_W-1:0]   ep_q;
  logic              setup_q, clr_setup_ep0, pol, pending;

  irq_sticky_bank #(.W(EP_W)) u_ep_bank (
    .clk(clk), .rst_n(rst_n), .set_i(ep_evt_i), .clr_i(clr1[DATA_W-1:1]), .q_o(ep_q));

  irq_sticky_bank #(.W(1)) u_setup_bank (
    .clk(clk), .rst_n(rst_n), .set_i(setup_evt_i),
    .clr_i(clr1[0] | clr_setup_ep0), .q_o(setup_q));

  irq_sticky_bank #(.W(DATA_W)) u_bus_bank (
    .clk(clk), .rst_n(rst_n), .set_i(bus_evt_i), .clr_i(clr2), .q_o(stat2));

  assign stat1    = {ep_q, setup_q};
  assign ep0_view = DATA_W'(setup_q) << EP0_SETUP_BIT;

  irq_regfile u_regs (
    .clk(clk), .rst_n(rst_n), .addr_i(addr_i), .rd_i(rd_i), .wr_i(wr_i),
    .wdata_i(wdata_i), .stat1_i(stat1), .stat2_i(stat2), .ep0_i(ep0_view),
    .clr1_o(clr1), .clr2_o(clr2), .clr_setup_ep0_o(clr_setup_ep0),
    .en1_o(en1), .en2_o(en2), .pol_o(pol), .rdata_o(rdata_o));

  assign pending = pending_of(stat1, en1, stat2, en2);
  assign irq_o   = pol ? pending : ~pending;

  // R5
  setup_mirror_chk: assert property (@(posedge clk) disable iff (!rst_n)
    setup_evt_i |=> (stat1[0] && ep0_view[EP0_SETUP_BIT]));

  // R7
  no_enable_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (en1 == '0 && en2 == '0) |-> (irq_o == !pol));
endmodule

// File: tb/irq_aggregator_bench.sv
module irq_aggregator_bench;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic [7:0] addr_i = '0;
  logic       rd_i = 1'b0;
  logic       wr_i = 1'b0;
  logic [7:0] wdata_i = '0;
  logic [7:0] rdata_o;
  logic [6:0] ep_evt_i = '0;
  logic       setup_evt_i = 1'b0;
  logic [7:0] bus_evt_i = '0;
  logic       irq_o;

  int checks = 0;
  int errors = 0;
  bit done = 0;

  typedef struct { logic [7:0] exp; string tag; logic [7:0] a; } exp_t;
  exp_t sb_q[$];

  always #2 clk = ~clk;

  irq_aggregator u_irq_aggregator (
    .clk(clk), .rst_n(rst_n), .addr_i(addr_i), .rd_i(rd_i), .wr_i(wr_i),
    .wdata_i(wdata_i), .rdata_o(rdata_o), .ep_evt_i(ep_evt_i),
    .setup_evt_i(setup_evt_i), .bus_evt_i(bus_evt_i), .irq_o(irq_o));

  // Monitor: compares read data against the scoreboard.
  always @(negedge clk) begin
    if (rd_i) begin
      checks++;
      if (sb_q.size() == 0) begin
        errors++;
        $display("FAIL scoreboard: read of %h with no expected item", addr_i);
      end else begin
        exp_t e;
        e = sb_q.pop_front();
        if (rdata_o !== e.exp) begin
          errors++;
          $display("FAIL %s: addr %h actual %h expected %h", e.tag, e.a, rdata_o, e.exp);
        end
      end
    end
  end

  task automatic bus_rd(input logic [7:0] a, input logic [7:0] exp, input string tag);
    exp_t e;
    e.exp = exp; e.tag = tag; e.a = a;
    sb_q.push_back(e);
    @(posedge clk); #1;
    addr_i = a; rd_i = 1'b1;
    @(posedge clk); #1;
    rd_i = 1'b0;
  endtask

  task automatic bus_wr(input logic [7:0] a, input logic [7:0] d);
    @(posedge clk); #1;
    addr_i = a; wdata_i = d; wr_i = 1'b1;
    @(posedge clk); #1;
    wr_i = 1'b0;
  endtask

  task automatic pulse(input logic [6:0] ep, input logic su, input logic [7:0] bus);
    @(posedge clk); #1;
    ep_evt_i = ep; setup_evt_i = su; bus_evt_i = bus;
    @(posedge clk); #1;
    ep_evt_i = '0; setup_evt_i = 1'b0; bus_evt_i = '0;
  endtask

  task automatic chk_irq(input logic exp, input string tag);
    @(negedge clk);
    checks++;
    if (irq_o !== exp) begin
      errors++;
      $display("FAIL %s: irq_o actual %b expected %b", tag, irq_o, exp);
    end
  endtask

  initial begin
    #1000000;
    if (!done) begin
      errors++;
      $display("FAIL watchdog: actual hung expected finish");
      $display("Result: errors=%0d of %0d checks", errors, checks + 1);
      $finish;
    end
  end

  initial begin
    repeat (3) @(posedge clk);
    #1 rst_n = 1'b1;
    // R1 reset state
    bus_rd(8'h21, 8'h00, "R1");
    bus_rd(8'h22, 8'h00, "R1");
    bus_rd(8'h24, 8'h00, "R1");
    bus_rd(8'h25, 8'h00, "R1");
    bus_rd(8'h30, 8'h00, "R1");
    bus_rd(8'h60, 8'h00, "R1");
    chk_irq(1'b1, "R1");
    // R2 mapping and stickiness
    pulse(7'b0000000, 1'b0, 8'h0B);
    bus_rd(8'h22, 8'h0B, "R2");
    pulse(7'b1000001, 1'b0, 8'h00);
    bus_rd(8'h21, 8'h82, "R2");
    chk_irq(1'b1, "R7 no enable");
    // R6 enable, R7/R8 active low
    bus_wr(8'h25, 8'h02);
    bus_rd(8'h25, 8'h02, "R6");
    chk_irq(1'b0, "R8 active low asserted");
    bus_wr(8'h30, 8'hFF);
    bus_rd(8'h30, 8'h01, "R8");
    chk_irq(1'b1, "R8 active high asserted");
    // R10 read does not clear
    bus_rd(8'h22, 8'h0B, "R10");
    bus_rd(8'h22, 8'h0B, "R10");
    // R3 selective clear
    bus_wr(8'h22, 8'h02);
    bus_rd(8'h22, 8'h09, "R3");
    chk_irq(1'b0, "R7 enable misses pending");
    // R4 set wins over clear
    @(posedge clk); #1;
    addr_i = 8'h22; wdata_i = 8'h08; wr_i = 1'b1; bus_evt_i = 8'h08;
    @(posedge clk); #1;
    wr_i = 1'b0; bus_evt_i = '0;
    bus_rd(8'h22, 8'h09, "R4");
    bus_wr(8'h22, 8'h08);
    bus_rd(8'h22, 8'h01, "R3");
    // R5 setup mirror and dual clear
    pulse(7'b0, 1'b1, 8'h00);
    bus_rd(8'h60, 8'h04, "R5");
    bus_rd(8'h21, 8'h83, "R5");
    bus_wr(8'h60, 8'hFB);
    bus_rd(8'h60, 8'h04, "R5 zero mask");
    bus_wr(8'h60, 8'h04);
    bus_rd(8'h21, 8'h82, "R5");
    bus_rd(8'h60, 8'h00, "R5");
    pulse(7'b0, 1'b1, 8'h00);
    bus_wr(8'h21, 8'h01);
    bus_rd(8'h60, 8'h00, "R5");
    bus_rd(8'h21, 8'h82, "R5");
    // R6 enable byte 1 gating
    bus_wr(8'h24, 8'h80);
    bus_rd(8'h24, 8'h80, "R6");
    chk_irq(1'b1, "R6 enable1 hit");
    bus_wr(8'h24, 8'h01);
    chk_irq(1'b0, "R6 enable1 miss");
    bus_wr(8'h24, 8'h00);
    // R9 unmapped
    bus_wr(8'h23, 8'hFF);
    bus_wr(8'h26, 8'hFF);
    bus_wr(8'h31, 8'hFF);
    bus_rd(8'h23, 8'h00, "R9");
    bus_rd(8'h61, 8'h00, "R9");
    bus_rd(8'h21, 8'h82, "R9");
    bus_rd(8'h22, 8'h01, "R9");
    bus_rd(8'h24, 8'h00, "R9");
    bus_rd(8'h25, 8'h02, "R9");
    bus_rd(8'h30, 8'h01, "R9");
    // R3 full clear
    bus_wr(8'h21, 8'hFF);
    bus_wr(8'h22, 8'hFF);
    bus_rd(8'h21, 8'h00, "R3");
    bus_rd(8'h22, 8'h00, "R3");
    bus_wr(8'h30, 8'h00);
    chk_irq(1'b1, "R8 idle active low");
    repeat (2) @(posedge clk);
    if (sb_q.size() != 0) begin
      errors++;
      $display("FAIL scoreboard: actual %0d items left expected 0", sb_q.size());
    end
    done = 1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule